// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block gathers the interrupt flags of a small processor system and decides which one the core should service next. Flags are grouped into numbered priority levels, several flags per level. A level is pending when at least one of its flags is set and allowed through. The controller reports the highest pending level and the 16-bit address of that level's vector word.

Each level belongs to one of four classes:
- **Reset:** the top level. It cannot be masked at all.
- **Nonmaskable:** the level just below reset. It obeys only the per-flag enables.
- **Maskable:** the band of ordinary levels. These need both the per-flag enable and the global interrupt enable.
- **Unused:** the lowest levels. They never request.

A separate guard watches instruction fetches. A fetch that lands in the low peripheral-register region raises a request at the reset level.

The gated pending vector is registered once. The level, address and strobe outputs are decoded from that register. The core's vector fetch, context stacking and the clearing of peripheral flags are handled elsewhere.

Top module: `ivc_vector_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `vec_valid_o`, `rst_req_o`, `vec_level_o` and `vec_addr_o` are all zero.
- R2: When valid, `vec_addr_o` equals 16'hFFC0 + 2 × `vec_level_o`, so level 31 maps to 16'hFFFE and level 0 to 16'hFFC0. When not valid, `vec_addr_o` is 0.
- R3: When several levels are pending together, only the numerically highest level is reported.
- R4: Flag bit `l*2+j` (j = 0 or 1) of `req_i` belongs to level `l` and is gated by the same bit of `ie_i`. A level is pending when any of its flags passes its gate.
- R5: Levels 14 to 29 are maskable. A flag there counts only when both its `ie_i` bit and `gie_i` are 1.
- R6: Level 30 is nonmaskable. Its flags count when their `ie_i` bit is 1, whatever the value of `gie_i`, and never when that bit is 0.
- R7: Level 31 flags count whenever set, regardless of `ie_i` and `gie_i`.
- R8: A fetch (`fetch_valid_i` = 1) at an address from 16'h0000 to 16'h01FF requests level 31. A fetch at 16'h0200 or above, or a fetch with the strobe low, does not.
- R9: Flags at levels 0 to 13 never make the controller report a request.
- R10: Outputs reflect the inputs sampled at the previous rising clock edge: one register of latency.
- R11: `rst_req_o` is 1 exactly when `vec_valid_o` is 1 and `vec_level_o` is 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| req_i | input | 64 | Interrupt flags, two per level |
| ie_i | input | 64 | Per-flag enables |
| gie_i | input | 1 | Global enable for maskable levels |
| fetch_valid_i | input | 1 | Instruction fetch in progress |
| fetch_addr_i | input | 16 | Address of that fetch |
| vec_valid_o | output | 1 | Some level is pending |
| vec_level_o | output | 5 | Highest pending level |
| vec_addr_o | output | 16 | Vector word address of that level |
| rst_req_o | output | 1 | Reset-level request reported |

## Verification
The bench uses the default parameters: 32 levels, two flags per level, a 16-bit address and a register region ending at 16'h01FF. With these values every class boundary can be reached.
- Levels 13/14 form the unused/maskable edge.
- Level 30 is the nonmaskable level.
- The fetch addresses 16'h01FF and 16'h0200 sit on either side of the register-region limit.

Sparse random flag patterns make many different levels win, including the second flag of a level. Directed cases pin down each class edge, the all-pending case and the fetch limit.

// File: rtl/ivc_pkg.sv
// Package ivc_pkg: level classes shared by the vector controller.
// Assumes the top two levels are reset and nonmaskable respectively.
package ivc_pkg;
    typedef enum logic [1:0] {
        CLS_UNUSED   = 2'd0,
        CLS_MASKABLE = 2'd1,
        CLS_NMI      = 2'd2,
        CLS_RESET    = 2'd3
    } lvl_class_e;

    // Map a level number to its class.
    function automatic lvl_class_e class_of(input int lvl, input int n_levels,
                                            input int first_used);
        if (lvl == n_levels - 1)      return CLS_RESET;
        else if (lvl == n_levels - 2) return CLS_NMI;
        else if (lvl >= first_used)   return CLS_MASKABLE;
        else                          return CLS_UNUSED;
    endfunction
endpackage

// File: rtl/ivc_level_gate.sv
// Module ivc_level_gate: decides whether one priority level is pending.
// Assumes CLS is fixed at elaboration; all gating is combinational.
module ivc_level_gate
    import ivc_pkg::*;
#(
    parameter int         FLAGS = 2,
    parameter lvl_class_e CLS   = CLS_MASKABLE
) (
    input  logic [FLAGS-1:0] req_i,
    input  logic [FLAGS-1:0] ie_i,
    input  logic             gie_i,
    output logic             pend_o
);
    localparam logic IE_BYPASS  = (CLS == CLS_RESET);
    localparam logic GIE_BYPASS = (CLS != CLS_MASKABLE);
    localparam logic USED       = (CLS != CLS_UNUSED);

    // Combine the flags of this level with the enables its class obeys.
    always_comb begin
        pend_o = USED & (|(req_i & (ie_i | {FLAGS{IE_BYPASS}})))
                      & (gie_i | GIE_BYPASS);
    end
endmodule

// File: rtl/ivc_fetch_guard.sv
// Module ivc_fetch_guard: flags instruction fetches from the register region.
// Assumes the region starts at address zero and ends at LIMIT inclusive.
module ivc_fetch_guard #(
    parameter int              ADDR_W = 16,
    parameter logic [ADDR_W-1:0] LIMIT = 16'h01FF
) (
    input  logic              fetch_valid_i,
    input  logic [ADDR_W-1:0] fetch_addr_i,
    output logic              hit_o
);
    // A fetch at or below the limit must force a reset request.
    always_comb begin
        hit_o = fetch_valid_i && (fetch_addr_i <= LIMIT);
    end
endmodule

// File: rtl/ivc_prio_enc.sv
// Module ivc_prio_enc: picks the highest pending level and forms its vector address.
// Assumes pend_i is already registered; the outputs are purely combinational.
module ivc_prio_enc #(
    parameter int                N      = 32,
    parameter int                LVL_W  = 5,
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE   = 16'hFFC0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N-1:0]      pend_i,
    output logic              valid_o,
    output logic [LVL_W-1:0]  level_o,
    output logic [ADDR_W-1:0] addr_o
);
    // Scan upward so the last set bit, the highest level, wins.
    always_comb begin
        valid_o = 1'b0;
        level_o = '0;
        for (int i = 0; i < N; i++) begin
            if (pend_i[i]) begin
                valid_o = 1'b1;
                level_o = LVL_W'(i);
            end
        end
    end

    // Each level owns one 16-bit word above the base.
    always_comb begin
        addr_o = valid_o ? (BASE + (ADDR_W'(level_o) << 1)) : '0;
    end

    // R3: nothing above the reported level may still be pending.
    a_r3_highest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> ((pend_i >> (int'(level_o) + 1)) == '0));
    // R2: an invalid output carries no address.
    a_r2_idle_addr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> (addr_o == '0) && (pend_i == '0));
endmodule

// File: rtl/ivc_vector_ctrl.sv
// Module ivc_vector_ctrl: prioritized interrupt vector controller (top).
// Gates the flags of every level by class, adds the fetch guard at the reset
// level, registers the pending vector and decodes the winner.
// Assumes a single clock and a synchronous active-low reset.
module ivc_vector_ctrl
    import ivc_pkg::*;
#(
    parameter int                NUM_LEVELS = 32,
    parameter int                FLAGS      = 2,
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] VEC_BASE   = 16'hFFC0,
    parameter int                FIRST_USED = 14,
    parameter logic [ADDR_W-1:0] REG_LIMIT  = 16'h01FF
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic [NUM_LEVELS*FLAGS-1:0] req_i,
    input  logic [NUM_LEVELS*FLAGS-1:0] ie_i,
    input  logic                        gie_i,
    input  logic                        fetch_valid_i,
    input  logic [ADDR_W-1:0]           fetch_addr_i,
    output logic                        vec_valid_o,
    output logic [$clog2(NUM_LEVELS)-1:0] vec_level_o,
    output logic [ADDR_W-1:0]           vec_addr_o,
    output logic                        rst_req_o
);
    localparam int LVL_W     = $clog2(NUM_LEVELS);
    localparam int RST_LEVEL = NUM_LEVELS - 1;
    localparam int NMI_LEVEL = NUM_LEVELS - 2;

    logic [NUM_LEVELS-1:0] gated_d;
    logic [NUM_LEVELS-1:0] pend_d;
    logic [NUM_LEVELS-1:0] pend_q;
    logic                  fetch_hit;
    logic                  past_ok_q;

    // One gate per level, its class chosen from the level number.
    for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
        ivc_level_gate #(
            .FLAGS (FLAGS),
            .CLS   (class_of(l, NUM_LEVELS, FIRST_USED))
        ) gate_i (
            .req_i  (req_i[l*FLAGS +: FLAGS]),
            .ie_i   (ie_i[l*FLAGS +: FLAGS]),
            .gie_i  (gie_i),
            .pend_o (gated_d[l])
        );
    end

    ivc_fetch_guard #(
        .ADDR_W (ADDR_W),
        .LIMIT  (REG_LIMIT)
    ) guard_i (
        .fetch_valid_i (fetch_valid_i),
        .fetch_addr_i  (fetch_addr_i),
        .hit_o         (fetch_hit)
    );

    // Merge the register-region fetch into the reset level.
    always_comb begin
        pend_d            = gated_d;
        pend_d[RST_LEVEL] = gated_d[RST_LEVEL] | fetch_hit;
    end

    // Register the pending vector once.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) pend_q <= '0;
        else         pend_q <= pend_d;
    end

    // Mark cycles whose previous edge was already out of reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) past_ok_q <= 1'b0;
        else         past_ok_q <= 1'b1;
    end

    ivc_prio_enc #(
        .N      (NUM_LEVELS),
        .LVL_W  (LVL_W),
        .ADDR_W (ADDR_W),
        .BASE   (VEC_BASE)
    ) enc_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pend_i  (pend_q),
        .valid_o (vec_valid_o),
        .level_o (vec_level_o),
        .addr_o  (vec_addr_o)
    );

    // The reset request follows the top bit of the registered vector.
    always_comb begin
        rst_req_o = pend_q[RST_LEVEL];
    end

    // R11: a reset request is always the reported, valid winner.
    a_r11_rst_is_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_o |-> vec_valid_o && (int'(vec_level_o) == RST_LEVEL));
    // R9: an unused level is never reported.
    a_r9_unused_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_valid_o |-> (int'(vec_level_o) >= FIRST_USED));
    // R5: a maskable winner implies the global enable was set one edge earlier.
    a_r5_gie_required: assert property (@(posedge clk_i) disable iff (!rst_ni)
        past_ok_q && vec_valid_o && (int'(vec_level_o) < NMI_LEVEL)
        |-> $past(gie_i));
    // R6: a nonmaskable winner implies one of its flags was enabled.
    a_r6_nmi_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        past_ok_q && vec_valid_o && (int'(vec_level_o) == NMI_LEVEL)
        |-> $past(|(req_i[NMI_LEVEL*FLAGS +: FLAGS] & ie_i[NMI_LEVEL*FLAGS +: FLAGS])));
    // R8: a fetch in the register region yields a reset request next cycle.
    a_r8_fetch_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        past_ok_q && $past(fetch_valid_i && (fetch_addr_i <= REG_LIMIT))
        |-> rst_req_o);
endmodule

// File: tb/ivc_vector_ctrl_tb.sv
// Bench for ivc_vector_ctrl: fixed-seed random flags plus directed corners,
// checked against a reference computed from the requirements.
module ivc_vector_ctrl_tb_top;
    localparam int NL = 32;
    localparam int FL = 2;
    localparam int NB = NL * FL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] req = '0;
    logic [NB-1:0] ie = '0;
    logic          gie = 1'b0;
    logic          fv = 1'b0;
    logic [15:0]   fa = '0;
    logic          vld;
    logic [4:0]    lvl;
    logic [15:0]   addr;
    logic          rreq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    ivc_vector_ctrl dut_i (
        .clk_i (clk), .rst_ni (rst_n), .req_i (req), .ie_i (ie), .gie_i (gie),
        .fetch_valid_i (fv), .fetch_addr_i (fa), .vec_valid_o (vld),
        .vec_level_o (lvl), .vec_addr_o (addr), .rst_req_o (rreq)
    );

    // Reference winner: -1 when nothing is pending.
    function automatic int ref_level(input logic [NB-1:0] r, input logic [NB-1:0] e,
                                     input logic g, input logic f, input logic [15:0] a);
        int best = -1;
        for (int l = 14; l < NL; l++) begin
            bit hit = 1'b0;
            for (int j = 0; j < FL; j++) begin
                if (l == 31)      hit |= r[l*FL+j];                 // R7
                else if (l == 30) hit |= r[l*FL+j] & e[l*FL+j];     // R6
                else              hit |= r[l*FL+j] & e[l*FL+j] & g; // R5, R4
            end
            if (l == 31 && f && a <= 16'h01FF) hit = 1'b1;           // R8
            if (hit) best = l;                                       // R3
        end
        return best;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive one vector, wait for the capturing edge, check the outputs (R10).
    task automatic apply(input logic [NB-1:0] r, input logic [NB-1:0] e,
                         input logic g, input logic f, input logic [15:0] a,
                         input string tag);
        int el;
        req = r; ie = e; gie = g; fv = f; fa = a;
        el = ref_level(r, e, g, f, a);
        @(posedge clk); #5;
        chk({tag, " R10 valid"}, 32'(vld), 32'(el >= 0));
        chk({tag, " R3 level"}, 32'(lvl), (el >= 0) ? 32'(el) : 32'd0);
        chk({tag, " R2 addr"}, 32'(addr), (el >= 0) ? 32'(16'hFFC0 + 16'(2*el)) : 32'd0);
        chk({tag, " R11 rst_req"}, 32'(rreq), 32'(el == 31));
    endtask

    function automatic logic [NB-1:0] bit_at(input int i);
        return NB'(1) << i;
    endfunction

    initial begin
        logic [NB-1:0] ones = '1;
        repeat (3) @(posedge clk);
        #5;
        // R1: outputs idle while held in reset, even with flags set.
        req = ones; ie = ones; gie = 1'b1;
        @(posedge clk); #5;
        chk("R1 valid in reset", 32'(vld), 0);
        chk("R1 level in reset", 32'(lvl), 0);
        chk("R1 addr in reset", 32'(addr), 0);
        chk("R1 rst_req in reset", 32'(rreq), 0);
        req = '0; ie = '0; gie = 1'b0;
        rst_n = 1'b1;
        @(posedge clk); #5;
        chk("R1 valid after reset", 32'(vld), 0);
        chk("R1 addr after reset", 32'(addr), 0);

        // Directed corners.
        apply(ones, ones, 1'b1, 1'b0, 16'h0, "R3 all pending");
        apply(bit_at(13*2), ones, 1'b1, 1'b0, 16'h0, "R9 level13");
        apply(ones & ~(bit_at(28)-1) & (bit_at(28)-1), ones, 1'b1, 1'b0, 16'h0, "R9 none");
        apply((bit_at(28)-1), ones, 1'b1, 1'b0, 16'h0, "R9 levels0-13");
        apply(bit_at(14*2), ones, 1'b1, 1'b0, 16'h0, "R5 level14 lowest");
        apply(bit_at(20*2+1), ones, 1'b1, 1'b0, 16'h0, "R4 second flag");
        apply(bit_at(20*2+1), ~bit_at(20*2+1), 1'b1, 1'b0, 16'h0, "R4 flag disabled");
        apply(bit_at(29*2), ones, 1'b0, 1'b0, 16'h0, "R5 gie off");
        apply(bit_at(30*2), ones, 1'b0, 1'b0, 16'h0, "R6 nmi gie off");
        apply(bit_at(30*2) | bit_at(30*2+1), '0, 1'b1, 1'b0, 16'h0, "R6 nmi ie off");
        apply(bit_at(31*2+1), '0, 1'b0, 1'b0, 16'h0, "R7 reset no enables");
        apply('0, '0, 1'b0, 1'b1, 16'h01FF, "R8 fetch 01FF");
        apply('0, '0, 1'b0, 1'b1, 16'h0000, "R8 fetch 0000");
        apply(bit_at(15*2), ones, 1'b1, 1'b1, 16'h0200, "R8 fetch 0200");
        apply('0, '0, 1'b0, 1'b0, 16'h0010, "R8 no strobe");

        // Constrained random: sparse flags, mostly-on enables.
        void'($urandom(32'h1234_5678));
        for (int n = 0; n < 3000; n++) begin
            logic [NB-1:0] r, e;
            logic [15:0]   a;
            r = {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom};
            if (($urandom % 3) == 0) r[63:56] = '0;
            e = ~{$urandom & $urandom, $urandom & $urandom};
            a = (($urandom % 8) == 0) ? 16'($urandom % 16'h0200) : 16'($urandom);
            apply(r, e, 1'($urandom), 1'($urandom), a, "R4 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule